// File: doc/BRIEF.md
# Full-frame CCD readout timing generator

This block produces the digital clock pattern for one exposure and readout of a two-phase full-frame CCD. After a start pulse, it holds every CCD clock static for a programmable integration time. It then reads the array line by line. Each line begins with a non-overlapping vertical transfer on two phase outputs, followed by a settling gap. The horizontal phases then shift out a fixed number of serial positions. Each position is one pixel period, and a reset pulse opens every period.

For an external converter, the block emits two sample strobes in every pixel period, one on the reset level and one on the signal level, so the converter can do correlated double sampling. It also emits a pulse at the start of each frame and at the start of each line. Each serial position carries a tag that marks it as dummy, dark reference or photoactive, together with its row and column index. All durations are counted in system clock cycles and are captured when a start is accepted. An abort input returns the block to idle.

Top module: `ccd_seq_top`

## Requirements
- R1: While reset is held, and after its release with no start, all clock outputs, strobes, `busy_o`, `row_o` and `col_o` are 0.
- R2: A `start_i` sampled high while idle captures all five durations; a zero duration is taken as one. The following `int_len_i` cycles are integration: `busy_o` is 1 and all four CCD clocks and `rst_o` are 0. Later changes on the duration inputs do not affect the frame.
- R3: Each line opens with `v1_o` high for the vertical width, immediately followed by `v2_o` high for the same width. The two are never high together, and `v2_o` rises only in the cycle after `v1_o` was high.
- R4: After `v2_o` falls, all clocks stay 0 for the settle count before the first pixel period of the line.
- R5: A line holds the serial-count number of pixel periods of P cycles each (count = sum of the five region widths). `h1_o` is high for the first floor(P/2) cycles of a period and `h2_o` is its complement throughout the readout.
- R6: `rst_o` is high for the first W cycles of every pixel period (valid settings: 1 <= W and W+2 <= P).
- R7: `smp_rst_o` pulses at cycle W of each pixel period and `smp_sig_o` at cycle P-1. `row_o` and `col_o` give the 0-based line and serial index.
- R8: `tag_o` encodes the column: 2'b00 dummy for the first 4 and last 2 positions, 2'b01 dark for the next 4 and the 8 before the last 2, and 2'b10 photoactive for the 512 in between (widths are parameters).
- R9: `frame_o` pulses in the first cycle of the first line's vertical transfer. `line_o` pulses in the first cycle of every line's first pixel period.
- R10: The frame has the parameterised number of lines (520 by default). `busy_o` falls right after the last pixel period of the last line.
- R11: A `start_i` while `busy_o` is high is ignored.
- R12: An `abort_i` sampled high makes every clock output, strobe, `busy_o`, `row_o` and `col_o` 0 in the next cycle. A later start runs a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin exposure and readout |
| abort_i | input | 1 | Return to idle |
| int_len_i | input | INT_W | Integration length, cycles |
| v_width_i | input | DUR_W | Width of each vertical phase, cycles |
| settle_i | input | DUR_W | Gap between vertical transfer and first pixel |
| pix_period_i | input | DUR_W | Pixel period P, cycles |
| rst_width_i | input | DUR_W | Reset pulse width W, cycles |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rst_o | output | 1 | Output-node reset clock |
| busy_o | output | 1 | Frame in progress |
| frame_o | output | 1 | Frame readout start pulse |
| line_o | output | 1 | Line readout start pulse |
| smp_rst_o | output | 1 | Reset-level sample strobe |
| smp_sig_o | output | 1 | Signal-level sample strobe |
| tag_o | output | 2 | Pixel class of current column |
| row_o | output | ROW_W | Current line index |
| col_o | output | COL_W | Current serial index |

## Verification
Two situations are the hardest to reach from the ports: a start that arrives in the last cycle of the last pixel period, just before `busy_o` falls, and an abort in the middle of a pixel period. Both need exact cycle counting against the frame length. The stimulus therefore works out the frame length from the durations it drives, and places a start request at a chosen cycle offset, including the final busy cycle. It also places aborts inside integration and inside readout. Random duration sets cover odd and even periods and the narrowest reset width, and every cycle is compared against a bench model of the full timeline.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    TAG_DUMMY  = 2'b00,
    TAG_DARK   = 2'b01,
    TAG_ACTIVE = 2'b10
  } pix_tag_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INTEG, ST_V1, ST_V2, ST_SETTLE, ST_PIX
  } seq_state_e;
endpackage

// File: rtl/ccd_pix_tagger.sv
module ccd_pix_tagger import ccd_seq_pkg::*; #(
  parameter int COL_W       = 10,
  parameter int DUMMY_HEAD  = 4,
  parameter int DARK_HEAD   = 4,
  parameter int ACTIVE_PIX  = 512,
  parameter int DARK_TAIL   = 8
) (
  input  logic [COL_W-1:0] col_i,
  output pix_tag_e         tag_o
);
  localparam logic [31:0] B_DARK0 = 32'(DUMMY_HEAD);
  localparam logic [31:0] B_ACT   = 32'(DUMMY_HEAD + DARK_HEAD);
  localparam logic [31:0] B_DARK1 = 32'(DUMMY_HEAD + DARK_HEAD + ACTIVE_PIX);
  localparam logic [31:0] B_DUM1  = 32'(DUMMY_HEAD + DARK_HEAD + ACTIVE_PIX + DARK_TAIL);

  logic [31:0] c;
  always_comb begin
    c = 32'(col_i);
    if (c < B_DARK0)      tag_o = TAG_DUMMY;
    else if (c < B_ACT)   tag_o = TAG_DARK;
    else if (c < B_DARK1) tag_o = TAG_ACTIVE;
    else if (c < B_DUM1)  tag_o = TAG_DARK;
    else                  tag_o = TAG_DUMMY;
  end
endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DUR_W-1:0] period_i,
  input  logic [DUR_W-1:0] rwidth_i,
  output logic             h_phase_o,
  output logic             rst_o,
  output logic             smp_rst_o,
  output logic             smp_sig_o,
  output logic             first_o,
  output logic             last_o
);
  logic [DUR_W-1:0] pcnt_q;

  assign last_o    = en_i && (pcnt_q == period_i - DUR_W'(1));
  assign first_o   = en_i && (pcnt_q == '0);
  assign h_phase_o = en_i && (pcnt_q < (period_i >> 1));
  assign rst_o     = en_i && (pcnt_q < rwidth_i);
  assign smp_rst_o = en_i && (pcnt_q == rwidth_i);
  assign smp_sig_o = last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!en_i || last_o)   pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + DUR_W'(1);
  end

  AST_PCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (pcnt_q < period_i)); // R5
  AST_SMP_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_rst_o && $past(en_i)) |-> $past(rst_o)); // R7
endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top import ccd_seq_pkg::*; #(
  parameter int N_LINES     = 520,
  parameter int DUMMY_HEAD  = 4,
  parameter int DARK_HEAD   = 4,
  parameter int ACTIVE_PIX  = 512,
  parameter int DARK_TAIL   = 8,
  parameter int DUMMY_TAIL  = 2,
  parameter int INT_W       = 24,
  parameter int DUR_W       = 16,
  parameter int N_COUNTS    = DUMMY_HEAD + DARK_HEAD + ACTIVE_PIX + DARK_TAIL + DUMMY_TAIL,
  parameter int ROW_W       = (N_LINES  > 1) ? $clog2(N_LINES)  : 1,
  parameter int COL_W       = (N_COUNTS > 1) ? $clog2(N_COUNTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [INT_W-1:0] int_len_i,
  input  logic [DUR_W-1:0] v_width_i,
  input  logic [DUR_W-1:0] settle_i,
  input  logic [DUR_W-1:0] pix_period_i,
  input  logic [DUR_W-1:0] rst_width_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             rst_o,
  output logic             busy_o,
  output logic             frame_o,
  output logic             line_o,
  output logic             smp_rst_o,
  output logic             smp_sig_o,
  output logic [1:0]       tag_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_LINES - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(N_COUNTS - 1);

  seq_state_e       state_q;
  logic [INT_W-1:0] tcnt_q, ti_q, dur_sel;
  logic [DUR_W-1:0] tv_q, ts_q, tp_q, tw_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             seg_done, pix_en, pix_last, pix_first, h_phase, rst_pulse;
  pix_tag_e         tag;

  function automatic logic [DUR_W-1:0] nz_d(input logic [DUR_W-1:0] x);
    return (x == '0) ? DUR_W'(1) : x;
  endfunction

  always_comb begin
    unique case (state_q)
      ST_INTEG:     dur_sel = ti_q;
      ST_V1, ST_V2: dur_sel = INT_W'(tv_q);
      ST_SETTLE:    dur_sel = INT_W'(ts_q);
      default:      dur_sel = INT_W'(1);
    endcase
  end
  assign seg_done = (tcnt_q == dur_sel - INT_W'(1));
  assign pix_en   = (state_q == ST_PIX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      ti_q    <= INT_W'(1);
      tv_q    <= DUR_W'(1);
      ts_q    <= DUR_W'(1);
      tp_q    <= DUR_W'(1);
      tw_q    <= DUR_W'(1);
      row_q   <= '0;
      col_q   <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_INTEG;
          tcnt_q  <= '0;
          ti_q    <= (int_len_i == '0) ? INT_W'(1) : int_len_i;
          tv_q    <= nz_d(v_width_i);
          ts_q    <= nz_d(settle_i);
          tp_q    <= nz_d(pix_period_i);
          tw_q    <= nz_d(rst_width_i);
        end
        ST_INTEG, ST_V1, ST_V2, ST_SETTLE: begin
          if (seg_done) begin
            tcnt_q <= '0;
            unique case (state_q)
              ST_INTEG: state_q <= ST_V1;
              ST_V1:    state_q <= ST_V2;
              ST_V2:    state_q <= ST_SETTLE;
              default:  state_q <= ST_PIX;
            endcase
          end else begin
            tcnt_q <= tcnt_q + INT_W'(1);
          end
        end
        ST_PIX: if (pix_last) begin
          if (col_q == LAST_COL) begin
            col_q <= '0;
            if (row_q == LAST_ROW) begin
              row_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              row_q   <= row_q + ROW_W'(1);
              state_q <= ST_V1;
            end
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ccd_pix_timer #(.DUR_W(DUR_W)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pix_en),
    .period_i  (tp_q),
    .rwidth_i  (tw_q),
    .h_phase_o (h_phase),
    .rst_o     (rst_pulse),
    .smp_rst_o (smp_rst_o),
    .smp_sig_o (smp_sig_o),
    .first_o   (pix_first),
    .last_o    (pix_last)
  );

  ccd_pix_tagger #(
    .COL_W(COL_W), .DUMMY_HEAD(DUMMY_HEAD), .DARK_HEAD(DARK_HEAD),
    .ACTIVE_PIX(ACTIVE_PIX), .DARK_TAIL(DARK_TAIL)
  ) u_tag (
    .col_i (col_q),
    .tag_o (tag)
  );

  assign v1_o    = (state_q == ST_V1);
  assign v2_o    = (state_q == ST_V2);
  assign h1_o    = pix_en && h_phase;
  assign h2_o    = pix_en && !h_phase;
  assign rst_o   = rst_pulse;
  assign busy_o  = (state_q != ST_IDLE);
  assign frame_o = v1_o && (row_q == '0) && (tcnt_q == '0);
  assign line_o  = pix_first && (col_q == '0);
  assign tag_o   = tag;
  assign row_o   = row_q;
  assign col_o   = col_q;

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !(v1_o || v2_o || h1_o || h2_o || rst_o || busy_o)); // R12
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i) |=> ($stable(tp_q) && $stable(tv_q) && $stable(ts_q) && $stable(tw_q) && $stable(ti_q))); // R11
  AST_V_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(v2_o) |-> $past(v1_o)); // R3
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(abort_i)) |-> $past(smp_sig_o)); // R10
  AST_LINE_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> (rst_o && col_o == '0)); // R9
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_q) |-> ((row_q == $past(row_q) + ROW_W'(1)) || (row_q == '0))); // R10
endmodule

// File: tb/ccd_seq_top_tb.sv
module ccd_seq_top_tb;
  localparam int L = 5, DH = 2, DKH = 2, ACT = 10, DKT = 3, DT = 1;
  localparam int C = DH + DKH + ACT + DKT + DT;
  localparam int INT_W = 24, DUR_W = 16, ROW_W = 3, COL_W = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, abort_i = 1'b0;
  logic [INT_W-1:0] int_len_i = '0;
  logic [DUR_W-1:0] v_width_i = '0, settle_i = '0, pix_period_i = '0, rst_width_i = '0;
  logic v1_o, v2_o, h1_o, h2_o, rst_o, busy_o, frame_o, line_o, smp_rst_o, smp_sig_o;
  logic [1:0] tag_o;
  logic [ROW_W-1:0] row_o;
  logic [COL_W-1:0] col_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ccd_seq_top #(
    .N_LINES(L), .DUMMY_HEAD(DH), .DARK_HEAD(DKH), .ACTIVE_PIX(ACT),
    .DARK_TAIL(DKT), .DUMMY_TAIL(DT), .INT_W(INT_W), .DUR_W(DUR_W)
  ) u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int tag_of(input int c);
    if (c < DH) return 0;
    if (c < DH + DKH) return 1;
    if (c < DH + DKH + ACT) return 2;
    if (c < DH + DKH + ACT + DKT) return 1;
    return 0;
  endfunction

  task automatic chk_idle(input string req);
    chk(req, "v1", int'(v1_o), 0);   chk(req, "v2", int'(v2_o), 0);
    chk(req, "h1", int'(h1_o), 0);   chk(req, "h2", int'(h2_o), 0);
    chk(req, "rst", int'(rst_o), 0); chk(req, "busy", int'(busy_o), 0);
    chk(req, "strobes", int'({frame_o, line_o, smp_rst_o, smp_sig_o}), 0);
    chk(req, "row", int'(row_o), 0); chk(req, "col", int'(col_o), 0);
  endtask

  // restart_k: cycle offset of an extra start (-1 none, -2 last busy cycle)
  task automatic run_frame(input int ti, input int tv, input int ts, input int p,
                           input int w, input int abort_k, input int restart_k);
    int ll, total, rk;
    ll = 2 * tv + ts + C * p;
    total = ti + L * ll;
    rk = (restart_k == -2) ? total - 1 : restart_k;
    @(negedge clk_i);
    int_len_i = INT_W'(ti); v_width_i = DUR_W'(tv); settle_i = DUR_W'(ts);
    pix_period_i = DUR_W'(p); rst_width_i = DUR_W'(w); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // scramble inputs after capture (R2)
    int_len_i = INT_W'(1 + $urandom % 7); v_width_i = DUR_W'(1 + $urandom % 9);
    settle_i = DUR_W'(1 + $urandom % 9); pix_period_i = DUR_W'(3 + $urandom % 9);
    rst_width_i = 1;
    for (int k = 0; k <= total; k++) begin
      int ev1, ev2, eh1, eh2, er, esr, ess, efr, eln, erow, ecol, r, o, q, col, pc;
      string ph;
      start_i = 1'b0;
      ev1 = 0; ev2 = 0; eh1 = 0; eh2 = 0; er = 0; esr = 0; ess = 0;
      efr = 0; eln = 0; erow = 0; ecol = 0; col = -1; ph = "R10";
      if (k < ti) ph = "R2";
      else if (k < total) begin
        r = (k - ti) / ll; o = (k - ti) % ll; erow = r;
        if (o < tv) begin ph = "R3"; ev1 = 1; efr = (r == 0 && o == 0); end
        else if (o < 2 * tv) begin ph = "R3"; ev2 = 1; end
        else if (o < 2 * tv + ts) ph = "R4";
        else begin
          ph = "R5"; q = o - 2 * tv - ts; col = q / p; pc = q % p; ecol = col;
          eh1 = (pc < p / 2); eh2 = !eh1; er = (pc < w);
          esr = (pc == w); ess = (pc == p - 1); eln = (q == 0);
        end
      end
      chk(ph, "v1", int'(v1_o), ev1);  chk(ph, "v2", int'(v2_o), ev2);
      chk(ph, "h1", int'(h1_o), eh1);  chk(ph, "h2", int'(h2_o), eh2);
      chk("R6", "rst", int'(rst_o), er);
      chk("R7", "smp_rst", int'(smp_rst_o), esr);
      chk("R7", "smp_sig", int'(smp_sig_o), ess);
      chk("R7", "row", int'(row_o), erow);
      chk("R7", "col", int'(col_o), ecol);
      chk("R9", "frame", int'(frame_o), efr);
      chk("R9", "line", int'(line_o), eln);
      chk("R10", "busy", int'(busy_o), int'(k < total));
      if (col >= 0) chk("R8", "tag", int'(tag_o), tag_of(col));
      if (k == total && restart_k != -1) chk("R11", "busy after ignored start", int'(busy_o), 0);
      if (k == abort_k) begin
        abort_i = 1'b1;
        @(negedge clk_i);
        abort_i = 1'b0;
        chk_idle("R12");
        return;
      end
      if (k == rk) start_i = 1'b1;
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED_0C0D);
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_idle("R1");
    run_frame(1, 1, 1, 3, 1, -1, -1);    // narrowest timing
    run_frame(5, 2, 3, 7, 2, -1, -1);    // odd period
    run_frame(3, 2, 2, 4, 2, -1, 40);    // start mid-frame (R11)
    run_frame(2, 1, 2, 5, 3, -1, -2);    // start in last busy cycle (R11)
    run_frame(10, 2, 2, 4, 1, 3, -1);    // abort during integration (R12)
    run_frame(2, 2, 2, 5, 2, 60, -1);    // abort mid pixel (R12)
    run_frame(4, 3, 1, 6, 3, -1, -1);    // recovery after abort (R12)
    for (int i = 0; i < 12; i++) begin
      int p, w;
      p = 3 + int'($urandom % 8);
      w = 1 + int'($urandom % (p - 2));
      run_frame(1 + int'($urandom % 20), 1 + int'($urandom % 4), 1 + int'($urandom % 5),
                p, w, -1, (i % 3 == 0) ? 25 + int'($urandom % 100) : -1);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule